// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block drives an external asynchronous bus of the static-memory kind, with up to four chip-select banks. Each bank has its own stored configuration: six strobe-timing counts, a data width of 8 or 16 bits, and a page-read mode. An internal requester presents a bank number, a byte offset, a direction and write data with a valid/ready handshake. The block then plays out the strobe timeline on the external pins and returns read data together with a one-cycle completion pulse.

A transfer has these phases in order: address setup, chip-select setup, the strobe window, chip-select hold and address hold. The block skips any phase whose count is zero. In page-read mode a single request fetches four consecutive items. The first item uses the full access window. Each later item uses only the shorter page-cycle count, and the strobe stays asserted across all four items.

Top module: `smem_bank_seq`

## Requirements
- R1: While reset is active and afterwards until the first request, req_ready is 1, rsp_done is 0, every mem_cs_n bit is 1, mem_oe_n and mem_we_n are 1 and mem_d_oe is 0.
- R2: A cfg_we pulse stores cfg_wdata into the bank given by cfg_bank. The layout is as follows. [3:0] is the address-setup count AS. [7:4] is the chip-select-setup count CS. [12:8] is the access count ACC. [16:13] is the chip-select-hold count CH. [20:17] is the address-hold count AH. [24:21] is the page-cycle count PG. [25] selects 16-bit width. [26] enables page reads. After reset every bank holds all zeros: 8-bit width, page reads off and zero timing. Writing one bank leaves the others unchanged.
- R3: Counted after the accepting clock edge, mem_cs_n stays high for AS cycles and then goes low. The strobe (mem_oe_n for reads, mem_we_n for writes) asserts CS cycles after that and stays low for ACC+1 cycles. Chip select is released CH cycles after the strobe releases. Address hold then lasts AH more cycles. A zero count adds no cycle.
- R4: rsp_done is high for exactly one cycle. It rises AS+CS+S+CH+AH cycles after the accepting edge, where S is the total number of strobe cycles. req_ready returns to 1 in the cycle after that.
- R5: For a 16-bit bank, mem_addr equals the byte offset shifted right by one. The read item is the full 16-bit mem_d_in value, sampled in the last strobe cycle.
- R6: For an 8-bit bank, mem_addr equals the byte offset. A read item is mem_d_in[7:0] with zero extension, and a write drives {8'h00, low byte of req_wdata}.
- R7: A read on a bank with page reads enabled transfers four items from addresses base, base+1, base+2 and base+3. Item k goes to rsp_rdata[16k+15:16k]. Items 1 to 3 each hold the strobe for PG cycles, with PG=0 counting as 1. A read without page mode fills only item 0 and leaves the rest zero.
- R8: A write asserts mem_we_n for ACC+1 cycles whether or not page mode is set, and drives req_wdata on mem_d_out. mem_d_oe rises together with chip select and falls one cycle after the address hold ends, so it is high for CS+ACC+1+CH+AH+1 cycles. mem_d_oe is never high during a read or while mem_oe_n is low.
- R9: Only the chip select of the requested bank goes low, and at most one is low at any time.
- R10: A bank's configuration is captured when its request is accepted. A cfg_we to that bank during the transfer only affects later transfers.
- R11: req_ready is 1 only when the sequencer is idle. It is 0 from the accepting edge until the cycle after rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank whose configuration is written |
| cfg_wdata | input | 27 | Configuration word (layout in R2) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_bank | input | 2 | Target bank |
| req_offset | input | ADDR_W | Byte offset inside the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read items, item k at [16k+15:16k] |
| mem_addr | output | ADDR_W | External address bus |
| mem_cs_n | output | NBANK | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_d_in | input | 16 | Data bus input |
| mem_d_out | output | 16 | Data bus output |
| mem_d_oe | output | 1 | Data bus drive enable |

## Verification
Every result is a function of the cycle count since the accepting edge. The bench drives each request on a falling edge and then samples once per following falling edge. It counts the cycles before chip select, the cycles with chip select low, the strobe cycles, the address-hold cycles and the drive-enable cycles. It compares each count with the sum that R3, R4, R7 and R8 give for the stored fields. It reads rsp_rdata and req_ready in the single cycle in which rsp_done is high. It checks req_ready again in the next cycle, because the pulse must last exactly one cycle.

// File: rtl/smem_bank_seq.sv
module smem_bank_seq #(
  parameter int ADDR_W = 16,
  parameter int NBANK  = 4,
  localparam int BW    = $clog2(NBANK),
  localparam int CFG_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BW-1:0]     cfg_bank,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BW-1:0]     req_bank,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [63:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic [15:0]       mem_d_in,
  output logic [15:0]       mem_d_out,
  output logic              mem_d_oe
);

  typedef enum logic [2:0] {
    S_IDLE, S_ASET, S_CSET, S_STRB, S_PAGE, S_CHOLD, S_AHOLD, S_DONE
  } st_t;

  logic [CFG_W-1:0]  cfg_q [NBANK];
  logic [CFG_W-1:0]  cur;
  st_t               st, st_n;
  logic [5:0]        cnt, len_n;
  logic [1:0]        item;
  logic [BW-1:0]     bank_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [15:0]       wd_q;
  logic [63:0]       rd_q;

  wire accept = req_valid && (st == S_IDLE);
  wire [CFG_W-1:0] c = accept ? cfg_q[req_bank] : cur;
  wire [3:0] t_as  = c[3:0];
  wire [3:0] t_cs  = c[7:4];
  wire [4:0] t_acc = c[12:8];
  wire [3:0] t_ch  = c[16:13];
  wire [3:0] t_ah  = c[20:17];
  wire [3:0] t_pg  = c[24:21];
  wire       w16   = c[25];
  wire       pmode = c[26];
  wire       wr_now  = accept ? req_write : wr_q;
  wire       page_rd = pmode && !wr_now;
  wire       last    = (cnt == 6'd1);
  wire       strobe  = (st == S_STRB) || (st == S_PAGE);
  wire       cs_act  = (st == S_CSET) || strobe || (st == S_CHOLD);

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (accept) st_n = (|t_as) ? S_ASET : (|t_cs) ? S_CSET : S_STRB;
      S_ASET:  if (last) st_n = (|t_cs) ? S_CSET : S_STRB;
      S_CSET:  if (last) st_n = S_STRB;
      S_STRB, S_PAGE:
        if (last)
          st_n = (page_rd && (st == S_STRB || item != 2'd3)) ? S_PAGE :
                 (|t_ch) ? S_CHOLD : (|t_ah) ? S_AHOLD : S_DONE;
      S_CHOLD: if (last) st_n = (|t_ah) ? S_AHOLD : S_DONE;
      S_AHOLD: if (last) st_n = S_DONE;
      default: st_n = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_n)
      S_ASET:  len_n = {2'b00, t_as};
      S_CSET:  len_n = {2'b00, t_cs};
      S_STRB:  len_n = {1'b0, t_acc} + 6'd1;
      S_PAGE:  len_n = (t_pg == 4'd0) ? 6'd1 : {2'b00, t_pg};
      S_CHOLD: len_n = {2'b00, t_ch};
      S_AHOLD: len_n = {2'b00, t_ah};
      default: len_n = 6'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) cfg_q[b] <= '0;
    end else if (cfg_we) begin
      cfg_q[cfg_bank] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= 6'd1;
      item   <= 2'd0;
      cur    <= '0;
      bank_q <= '0;
      wr_q   <= 1'b0;
      base_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      st <= st_n;
      if (accept || (st != S_IDLE && last)) cnt <= len_n;
      else if (st != S_IDLE) cnt <= cnt - 6'd1;
      if (accept) begin
        cur    <= cfg_q[req_bank];
        bank_q <= req_bank;
        wr_q   <= req_write;
        wd_q   <= req_wdata;
        base_q <= w16 ? (req_offset >> 1) : req_offset;
        item   <= 2'd0;
        rd_q   <= '0;
      end else if (strobe && last) begin
        if (!wr_q) rd_q[item*16 +: 16] <= w16 ? mem_d_in : {8'h00, mem_d_in[7:0]};
        if (st_n == S_PAGE) item <= item + 2'd1;
      end
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_DONE);
  assign rsp_rdata = rd_q;
  assign mem_addr  = base_q + ADDR_W'(item);
  assign mem_cs_n  = cs_act ? ~(NBANK'(1) << bank_q) : '1;
  assign mem_oe_n  = !(strobe && !wr_q);
  assign mem_we_n  = !(strobe && wr_q);
  assign mem_d_out = cur[25] ? wd_q : {8'h00, wd_q[7:0]};
  assign mem_d_oe  = wr_q && (cs_act || st == S_AHOLD || st == S_DONE);

  assert_single_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));
  assert_oe_we_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  assert_doe_not_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_d_oe |-> mem_oe_n);
  assert_doe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_d_oe) |-> (mem_cs_n == '1));
  assert_we_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_d_oe);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/smem_bank_seq_test.sv
module smem_bank_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_bank;
  logic [26:0] cfg_wdata;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_bank;
  logic [15:0] req_offset, req_wdata;
  logic        rsp_done;
  logic [63:0] rsp_rdata;
  logic [15:0] mem_addr, mem_d_in, mem_d_out;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_d_oe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  smem_bank_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_offset(req_offset), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_d_in(mem_d_in),
    .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe));

  function automatic logic [15:0] model(input logic [15:0] a);
    return {~a[7:0], a[7:0] ^ 8'h5A};
  endfunction

  assign mem_d_in = model(mem_addr);

  // {bank, write, offset, wdata, page, w16, PG, AH, CH, ACC, CS, AS}
  localparam logic [61:0] VEC [6] = '{
    {2'd0, 1'b0, 16'h0010, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd0,  4'd0,  5'd0,  4'd0,  4'd0},
    {2'd1, 1'b0, 16'h0046, 16'h0000, 1'b0, 1'b1, 4'd0, 4'd1,  4'd2,  5'd3,  4'd1,  4'd2},
    {2'd2, 1'b1, 16'h0077, 16'hBEEF, 1'b0, 1'b0, 4'd0, 4'd2,  4'd1,  5'd1,  4'd2,  4'd1},
    {2'd3, 1'b0, 16'h0100, 16'h0000, 1'b1, 1'b1, 4'd3, 4'd1,  4'd1,  5'd9,  4'd1,  4'd1},
    {2'd3, 1'b1, 16'h0222, 16'h1234, 1'b1, 1'b1, 4'd5, 4'd0,  4'd0,  5'd2,  4'd0,  4'd0},
    {2'd1, 1'b0, 16'h00FE, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd15, 4'd15, 5'd31, 4'd15, 4'd15}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] b, input logic [26:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = b; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [1:0] bank, input logic wr, input logic [15:0] off,
                     input logic [15:0] wd, input logic [26:0] cfg);
    int as_c, cs_c, acc_c, ch_c, ah_c, pg_c, estb, p, pre, csc, stb, post, doe, badcs, rdy;
    bit w16, pm, seen;
    logic [15:0] base, a_first, a_last, wdat, m;
    logic [63:0] exp_rd;
    as_c = cfg[3:0]; cs_c = cfg[7:4]; acc_c = cfg[12:8]; ch_c = cfg[16:13];
    ah_c = cfg[20:17]; pg_c = cfg[24:21]; w16 = cfg[25]; pm = cfg[26];
    base = w16 ? (off >> 1) : off;
    estb = acc_c + 1 + ((pm && !wr) ? 3 * ((pg_c == 0) ? 1 : pg_c) : 0);
    p = 0; pre = 0; csc = 0; stb = 0; post = 0; doe = 0; badcs = 0; rdy = 0; seen = 0;
    a_first = '0; a_last = '0; wdat = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_bank = bank; req_write = wr; req_offset = off; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done && p < 3000) begin
      if (mem_cs_n == 4'hF) begin
        if (!seen) pre++; else post++;
      end else begin
        seen = 1; csc++;
        if (mem_cs_n != ~(4'b0001 << bank)) badcs++;
      end
      if (!mem_oe_n || !mem_we_n) begin
        if (stb == 0) a_first = mem_addr;
        a_last = mem_addr;
        stb++;
        if (!mem_we_n) wdat = mem_d_out;
      end
      if (mem_d_oe) doe++;
      if (req_ready) rdy++;
      p++;
      @(negedge clk);
    end
    chk("R4 watchdog: done seen", {63'd0, rsp_done}, 64'd1);
    if (mem_d_oe) doe++;
    chk("R3 cycles before chip select", pre, as_c);
    chk("R3 chip select low cycles", csc, cs_c + estb + ch_c);
    chk("R3 address hold cycles", post, ah_c);
    chk(pm && !wr ? "R7 page strobe cycles" : "R3 strobe cycles", stb, estb);
    chk("R4 done delay", p, as_c + cs_c + estb + ch_c + ah_c);
    chk("R9 only selected bank", badcs, 0);
    chk("R11 ready low while busy", rdy + {31'd0, req_ready}, 0);
    chk(w16 ? "R5 first address" : "R6 first address", a_first, base);
    if (wr) begin
      chk("R8 write data", wdat, w16 ? wd : {8'h00, wd[7:0]});
      chk("R8 drive enable cycles", doe, cs_c + acc_c + 1 + ch_c + ah_c + 1);
    end else begin
      exp_rd = '0;
      for (int k = 0; k < 4; k++) begin
        if (k == 0 || pm) begin
          m = model(base + 16'(k));
          exp_rd[k*16 +: 16] = w16 ? m : {8'h00, m[7:0]};
        end
      end
      chk(pm ? "R7 page read data" : (w16 ? "R5 read data" : "R6 read data"), rsp_rdata, exp_rd);
      chk("R7 last address", a_last, base + (pm ? 16'd3 : 16'd0));
      chk("R8 no drive on read", doe, 0);
    end
    @(negedge clk);
    chk("R4 single-cycle done", {62'd0, rsp_done, req_ready}, 64'd1);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [26:0] newcfg;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_bank = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_bank = '0; req_offset = '0; req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready/done", {62'd0, req_ready, rsp_done}, 64'd2);
    chk("R1 reset strobes", {mem_cs_n, mem_oe_n, mem_we_n, mem_d_oe}, 7'b1111110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {mem_cs_n, req_ready, mem_d_oe}, 6'b111110);

    run(2'd2, 1'b0, 16'h0031, 16'h0, 27'h0);   // R2 default config

    for (int i = 0; i < 6; i++) begin
      cfg_write(VEC[i][61:60], VEC[i][26:0]);
      run(VEC[i][61:60], VEC[i][59], VEC[i][58:43], VEC[i][42:27], VEC[i][26:0]);
    end

    run(2'd0, 1'b0, 16'h0055, 16'h0, VEC[0][26:0]);   // R2 bank 0 kept its own config

    newcfg = {1'b0, 1'b1, 4'd0, 4'd2, 4'd0, 5'd4, 4'd0, 4'd3};
    fork
      run(2'd1, 1'b0, 16'h0010, 16'h0, VEC[5][26:0]);   // R10 snapshot kept
      begin
        repeat (6) @(negedge clk);
        cfg_write(2'd1, newcfg);
      end
    join
    run(2'd1, 1'b0, 16'h0020, 16'h0, newcfg);           // R10 new config applies next

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule